// File: doc/BRIEF.md
# Predictive Thermal Frequency Selector

This block picks a clock level for a multicore die before the die gets hot. When a new set of per-core temperature readings arrives (once per control period), it projects every core's temperature one step ahead with a linear state-space step. Each projection is a weighted sum of all current core temperatures plus an offset term. The offset depends on the core's current workload phase and on the candidate clock level. The weights, which model heat coupling between cores, are the same for every phase and level.

The selector tries candidate levels from the fastest down. For each level it takes the hottest projected core and stops at the first level whose hottest projection stays at or below a hard temperature limit. If no level fits, it settles on the slowest level and raises a flag. The coupling weights and the offset table are fixed at build time through parameters. The coupling sum does not depend on the level, so it is computed once per evaluation through a single shared multiplier. The level scan then only adds offsets.

Top module: `thermal_freq_select`

## Requirements
- R1: The projected temperature of core i is floor((sum over j of W[i][j]*T[j]) / 2^14) + OFS[i][phase_i][level]. Here T is an unsigned 10-bit count of quarter degrees, W is a signed 16-bit weight with 14 fraction bits, and OFS is a signed 12-bit count of quarter degrees.
- R2: The offset each core uses is selected by that core's own phase input (core i's phase sits at bits [2i+1:2i] of `core_phase`; core i's temperature sits at bits [10i+9:10i] of `core_temp`). The same weights serve every phase and level.
- R3: Each projection is clamped to the range 0 to 1023 before it is compared.
- R4: The worst case for a level is the maximum clamped projection over all cores. `peak_temp` reports that maximum for the level that was reported.
- R5: The reported level is the highest of levels 0 to 10 whose worst case is less than or equal to `hard_limit`. A worst case equal to the limit passes.
- R6: If no level passes, `freq_lvl` is 0, `peak_temp` is the worst case at level 0, and `no_fit` is 1. Otherwise `no_fit` is 0.
- R7: `done` is a one-cycle pulse. It rises N*N+1+m clock edges after the edge that accepts `start`, where N is the core count and m is the number of levels examined: 11 minus the chosen level when a level passes, 11 when none does.
- R8: A `start` pulse while an evaluation is in progress is ignored. Inputs are sampled only at the accepted `start` edge, so later input changes do not alter the result.
- R9: After reset `done`, `freq_lvl`, `peak_temp` and `no_fit` are all 0. The result outputs hold their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an evaluation with the present inputs |
| hard_limit | input | 10 | Temperature ceiling in quarter degrees |
| core_temp | input | 40 | Current temperature of each core, 10 bits per core |
| core_phase | input | 8 | Workload phase index of each core, 2 bits per core |
| done | output | 1 | Result valid pulse |
| freq_lvl | output | 4 | Chosen clock level, 0 slowest to 10 fastest |
| peak_temp | output | 10 | Worst projected temperature at the chosen level |
| no_fit | output | 1 | No level met the limit |

## Verification
The result lands N*N+1+m edges after the accepting edge: 16 edges of coupling sums, one hand-off edge, and one edge per level examined. m is known in advance from the bench's own model of the level scan. The bench counts edges from the accepting edge to the first `done` it sees, sampling half a cycle after each edge. It compares that count with 17+m before reading the level, peak and flag. For the ignored-start and hold cases it keeps watching the outputs over the following cycles to confirm that nothing moves and no second pulse appears.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    localparam int TW     = 10;
    localparam int CW     = 16;
    localparam int OW     = 12;
    localparam int FRAC   = 14;
    localparam int PROD_W = CW + TW + 1;
    localparam int ACC_W  = PROD_W + 4;
    localparam int BASE_W = ACC_W - FRAC;
    localparam int SUM_W  = BASE_W + 1;

    localparam int DEF_CORES  = 4;
    localparam int DEF_PHASES = 4;
    localparam int DEF_LEVELS = 11;

    typedef logic [TW-1:0]                temp_t;
    typedef logic signed [BASE_W-1:0]     base_t;
    typedef logic signed [SUM_W-1:0]      sum_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_SCAN = 2'd2
    } sel_state_t;

    localparam sum_t TMAX_S = sum_t'((1 << TW) - 1);

    function automatic temp_t clamp_temp(input sum_t v);
        if (v < 0)
            return '0;
        else if (v > TMAX_S)
            return '1;
        else
            return v[TW-1:0];
    endfunction

    function automatic logic [DEF_CORES*DEF_CORES*CW-1:0] default_coupling();
        logic [DEF_CORES*DEF_CORES*CW-1:0] r;
        r = '0;
        for (int i = 0; i < DEF_CORES; i++)
            for (int j = 0; j < DEF_CORES; j++)
                r[(i*DEF_CORES+j)*CW +: CW] = (i == j) ? 16'sd12288 : 16'sd1024;
        return r;
    endfunction

    function automatic logic [DEF_CORES*DEF_PHASES*DEF_LEVELS*OW-1:0] default_offsets();
        logic [DEF_CORES*DEF_PHASES*DEF_LEVELS*OW-1:0] r;
        r = '0;
        for (int i = 0; i < DEF_CORES; i++)
            for (int p = 0; p < DEF_PHASES; p++)
                for (int l = 0; l < DEF_LEVELS; l++)
                    r[((i*DEF_PHASES+p)*DEF_LEVELS+l)*OW +: OW] = OW'(8*l + 12*p + 2*i);
        return r;
    endfunction

endpackage

// File: rtl/tfs_coupling_mac.sv
module tfs_coupling_mac
    import tfs_pkg::*;
#(
    parameter int NCORE = 4,
    parameter logic [NCORE*NCORE*CW-1:0] CPL = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  temp_t temp_q [NCORE],
    output base_t base   [NCORE],
    output logic  fin
);
    localparam int CIW = (NCORE > 1) ? $clog2(NCORE) : 1;

    logic                     running;
    logic [CIW-1:0]           row, col;
    logic signed [ACC_W-1:0]  acc, acc_next;
    logic signed [PROD_W-1:0] prod;
    logic signed [CW-1:0]     coef;

    always_comb begin
        coef     = CPL[(int'(row)*NCORE + int'(col))*CW +: CW];
        prod     = coef * $signed({1'b0, temp_q[col]});
        acc_next = acc + ACC_W'(prod);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            row     <= '0;
            col     <= '0;
            acc     <= '0;
            fin     <= 1'b0;
            for (int i = 0; i < NCORE; i++) base[i] <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                running <= 1'b1;
                row     <= '0;
                col     <= '0;
                acc     <= '0;
            end else if (running) begin
                if (col == CIW'(NCORE-1)) begin
                    base[row] <= BASE_W'(acc_next >>> FRAC);
                    acc       <= '0;
                    col       <= '0;
                    if (row == CIW'(NCORE-1)) begin
                        running <= 1'b0;
                        fin     <= 1'b1;
                    end else begin
                        row <= row + 1'b1;
                    end
                end else begin
                    acc <= acc_next;
                    col <= col + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tfs_level_eval.sv
module tfs_level_eval
    import tfs_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int NPHASE = 4,
    parameter int NLVL   = 11,
    parameter int PW     = 2,
    parameter int LW     = 4,
    parameter logic [NCORE*NPHASE*NLVL*OW-1:0] OFS = '0
) (
    input  base_t          base  [NCORE],
    input  logic [PW-1:0]  phase [NCORE],
    input  logic [LW-1:0]  lvl,
    output temp_t          peak
);
    temp_t proj [NCORE];

    for (genvar i = 0; i < NCORE; i++) begin : g_core
        int                   idx;
        logic signed [OW-1:0] ofs_v;
        sum_t                 sum_v;
        always_comb begin
            idx     = (i*NPHASE + int'(phase[i]))*NLVL + int'(lvl);
            ofs_v   = OFS[idx*OW +: OW];
            sum_v   = SUM_W'(base[i]) + SUM_W'(ofs_v);
            proj[i] = clamp_temp(sum_v);
        end
    end

    always_comb begin
        peak = proj[0];
        for (int i = 1; i < NCORE; i++)
            if (proj[i] > peak) peak = proj[i];
    end
endmodule

// File: rtl/thermal_freq_select.sv
module thermal_freq_select
    import tfs_pkg::*;
#(
    parameter int NCORE  = DEF_CORES,
    parameter int NPHASE = DEF_PHASES,
    parameter int NLVL   = DEF_LEVELS,
    parameter logic [NCORE*NCORE*CW-1:0]        CPL = default_coupling(),
    parameter logic [NCORE*NPHASE*NLVL*OW-1:0]  OFS = default_offsets(),
    localparam int PW = (NPHASE > 1) ? $clog2(NPHASE) : 1,
    localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [TW-1:0]       hard_limit,
    input  logic [NCORE*TW-1:0] core_temp,
    input  logic [NCORE*PW-1:0] core_phase,
    output logic                done,
    output logic [LW-1:0]       freq_lvl,
    output logic [TW-1:0]       peak_temp,
    output logic                no_fit
);
    sel_state_t     state;
    logic [LW-1:0]  lvl;
    temp_t          lim_q;
    temp_t          temp_q  [NCORE];
    logic [PW-1:0]  phase_q [NCORE];
    base_t          base    [NCORE];
    temp_t          eval_peak;
    logic           mac_fin;
    logic           accept;
    logic           busy;

    assign accept = (state == ST_IDLE) && start;
    assign busy   = (state != ST_IDLE);

    tfs_coupling_mac #(.NCORE(NCORE), .CPL(CPL)) u_mac (
        .clk    (clk),
        .rst    (rst),
        .go     (accept),
        .temp_q (temp_q),
        .base   (base),
        .fin    (mac_fin)
    );

    tfs_level_eval #(
        .NCORE(NCORE), .NPHASE(NPHASE), .NLVL(NLVL),
        .PW(PW), .LW(LW), .OFS(OFS)
    ) u_eval (
        .base  (base),
        .phase (phase_q),
        .lvl   (lvl),
        .peak  (eval_peak)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            lvl       <= '0;
            lim_q     <= '0;
            done      <= 1'b0;
            freq_lvl  <= '0;
            peak_temp <= '0;
            no_fit    <= 1'b0;
            for (int i = 0; i < NCORE; i++) begin
                temp_q[i]  <= '0;
                phase_q[i] <= '0;
            end
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        lim_q <= hard_limit;
                        for (int i = 0; i < NCORE; i++) begin
                            temp_q[i]  <= core_temp[i*TW +: TW];
                            phase_q[i] <= core_phase[i*PW +: PW];
                        end
                        state <= ST_MAC;
                    end
                end
                ST_MAC: begin
                    if (mac_fin) begin
                        lvl   <= LW'(NLVL-1);
                        state <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (eval_peak <= lim_q) begin
                        freq_lvl  <= lvl;
                        peak_temp <= eval_peak;
                        no_fit    <= 1'b0;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (lvl == '0) begin
                        freq_lvl  <= '0;
                        peak_temp <= eval_peak;
                        no_fit    <= 1'b1;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        lvl <= lvl - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tfs_checker.sv
module tfs_checker #(
    parameter int LW = 4,
    parameter int TW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          no_fit,
    input logic [LW-1:0] freq_lvl,
    input logic [TW-1:0] peak_temp,
    input logic [TW-1:0] lim_q
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_after_work_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R6
    nofit_slowest_chk: assert property (@(posedge clk) disable iff (rst)
        (done && no_fit) |-> (freq_lvl == '0));

    // R5
    fit_under_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !no_fit) |-> (peak_temp <= lim_q));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(freq_lvl) && $stable(peak_temp) && $stable(no_fit)));

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(lim_q));
endmodule

bind thermal_freq_select tfs_checker #(.LW(LW), .TW(tfs_pkg::TW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .no_fit    (no_fit),
    .freq_lvl  (freq_lvl),
    .peak_temp (peak_temp),
    .lim_q     (lim_q)
);

// File: tb/tb_thermal_freq_select.sv
module tb_thermal_freq_select;

    localparam int NC = 4;
    localparam int NP = 4;
    localparam int NL = 11;

    function automatic int cpl_c(int i, int j);
        if (i == j) return 13107;
        if (i - j == 1 || j - i == 1) return 1638;
        return -492;
    endfunction

    function automatic int ofs_c(int i, int p, int l);
        return -40 + 9*l + 14*p + 4*i;
    endfunction

    function automatic logic [NC*NC*16-1:0] build_cpl();
        logic [NC*NC*16-1:0] r;
        for (int i = 0; i < NC; i++)
            for (int j = 0; j < NC; j++)
                r[(i*NC+j)*16 +: 16] = 16'(cpl_c(i, j));
        return r;
    endfunction

    function automatic logic [NC*NP*NL*12-1:0] build_ofs();
        logic [NC*NP*NL*12-1:0] r;
        for (int i = 0; i < NC; i++)
            for (int p = 0; p < NP; p++)
                for (int l = 0; l < NL; l++)
                    r[((i*NP+p)*NL+l)*12 +: 12] = 12'(ofs_c(i, p, l));
        return r;
    endfunction

    localparam logic [NC*NC*16-1:0]    TB_CPL = build_cpl();
    localparam logic [NC*NP*NL*12-1:0] TB_OFS = build_ofs();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [9:0]  hard_limit = '0;
    logic [39:0] core_temp = '0;
    logic [7:0]  core_phase = '0;
    logic        done;
    logic [3:0]  freq_lvl;
    logic [9:0]  peak_temp;
    logic        no_fit;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    thermal_freq_select #(.NCORE(NC), .NPHASE(NP), .NLVL(NL),
                          .CPL(TB_CPL), .OFS(TB_OFS)) dut (
        .clk(clk), .rst(rst), .start(start), .hard_limit(hard_limit),
        .core_temp(core_temp), .core_phase(core_phase), .done(done),
        .freq_lvl(freq_lvl), .peak_temp(peak_temp), .no_fit(no_fit)
    );

    typedef struct packed {
        logic [3:0][9:0] t;
        logic [3:0][1:0] p;
        logic [9:0]      lim;
    } vec_t;

    // fields listed core3 first
    localparam vec_t VEC [8] = '{
        '{ {10'd200, 10'd200, 10'd200, 10'd200}, {2'd0, 2'd0, 2'd0, 2'd0}, 10'd260 },
        '{ {10'd220, 10'd190, 10'd210, 10'd180}, {2'd3, 2'd0, 2'd2, 2'd1}, 10'd240 },
        '{ {10'd220, 10'd220, 10'd220, 10'd220}, {2'd3, 2'd3, 2'd3, 2'd3}, 10'd240 },
        '{ {10'd180, 10'd170, 10'd160, 10'd150}, {2'd1, 2'd2, 2'd1, 2'd2}, 10'd230 },
        '{ {10'd100, 10'd100, 10'd100, 10'd240}, {2'd0, 2'd3, 2'd0, 2'd0}, 10'd250 },
        '{ {10'd330, 10'd320, 10'd310, 10'd300}, {2'd0, 2'd0, 2'd0, 2'd0}, 10'd200 },
        '{ {10'd160, 10'd140, 10'd120, 10'd100}, {2'd0, 2'd1, 2'd2, 2'd3}, 10'd300 },
        '{ {10'd0,   10'd0,   10'd0,   10'd0  }, {2'd0, 2'd0, 2'd0, 2'd0}, 10'd0   }
    };

    function automatic int model_peak(int t[4], int p[4], int l);
        int pk = 0;
        for (int i = 0; i < NC; i++) begin
            longint s = 0;
            int v;
            for (int j = 0; j < NC; j++) s += longint'(cpl_c(i, j)) * t[j];
            s = s >>> 14;
            v = int'(s) + ofs_c(i, p[i], l);
            if (v < 0) v = 0;
            if (v > 1023) v = 1023;
            if (v > pk) pk = v;
        end
        return pk;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic drive(input int t[4], input int p[4], input int lim);
        for (int i = 0; i < NC; i++) begin
            core_temp[i*10 +: 10] = 10'(t[i]);
            core_phase[i*2 +: 2]  = 2'(p[i]);
        end
        hard_limit = 10'(lim);
    endtask

    // expected level, peak, flag and edge count from the requirements
    task automatic expect_of(input int t[4], input int p[4], input int lim,
                             output int el, output int ep, output int ef, output int em);
        el = -1;
        for (int l = NL-1; l >= 0; l--) begin
            if (el < 0 && model_peak(t, p, l) <= lim) el = l;
        end
        if (el >= 0) begin
            ep = model_peak(t, p, el); ef = 0; em = NL - el;
        end else begin
            el = 0; ep = model_peak(t, p, 0); ef = 1; em = NL;
        end
    endtask

    task automatic wait_done(output int n);
        bit got = 0;
        n = 0;
        while (!got && n < 80) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (done) got = 1;
        end
    endtask

    task automatic run_case(input int t[4], input int p[4], input int lim, input string tag);
        int el, ep, ef, em, n;
        expect_of(t, p, lim, el, ep, ef, em);
        @(negedge clk);
        drive(t, p, lim);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_done(n);
        check(n == NC*NC+1+em, "R7", {tag, " latency"}, n, NC*NC+1+em);
        check(freq_lvl == 4'(el), "R5", {tag, " level"}, int'(freq_lvl), el);
        check(peak_temp == 10'(ep), "R4", {tag, " peak"}, int'(peak_temp), ep);
        check(no_fit == ef[0], "R6", {tag, " no_fit"}, int'(no_fit), ef);
    endtask

    initial begin
        int t[4];
        int p[4];
        int pk;
        int el, ep, ef, em, n;
        logic [3:0] hl;
        logic [9:0] hp;
        int extra;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check(done == 1'b0,  "R9", "reset done",   int'(done), 0);
        check(freq_lvl == 0, "R9", "reset level",  int'(freq_lvl), 0);
        check(peak_temp == 0,"R9", "reset peak",   int'(peak_temp), 0);
        check(no_fit == 1'b0,"R9", "reset no_fit", int'(no_fit), 0);
        rst = 1'b0;

        // table walk: R1 R2 R3 R4 R5 R6 R7
        foreach (VEC[k]) begin
            for (int i = 0; i < NC; i++) begin
                t[i] = int'(VEC[k].t[i]);
                p[i] = int'(VEC[k].p[i]);
            end
            run_case(t, p, int'(VEC[k].lim), $sformatf("R1 vec%0d", k));
        end

        // R5 equality at the top level passes
        t = '{200, 200, 200, 200}; p = '{1, 1, 1, 1};
        pk = model_peak(t, p, NL-1);
        run_case(t, p, pk, "R5 equal");
        run_case(t, p, pk - 1, "R5 one below");

        // R2 phase selection matters: same temps, different phases
        t = '{210, 210, 210, 210}; p = '{3, 0, 0, 0};
        run_case(t, p, 250, "R2 phaseA");
        p = '{0, 0, 0, 3};
        run_case(t, p, 250, "R2 phaseB");

        // R3 upper clamp
        t = '{1023, 1023, 1023, 1023}; p = '{3, 3, 3, 3};
        run_case(t, p, 1023, "R3 clamp high");

        // R8 start during work ignored, inputs sampled at accept
        t = '{180, 190, 200, 210}; p = '{1, 2, 1, 0};
        expect_of(t, p, 235, el, ep, ef, em);
        @(negedge clk);
        drive(t, p, 235);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        drive('{900, 900, 900, 900}, '{3, 3, 3, 3}, 5);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 4;
        begin
            int m;
            wait_done(m);
            n += m;
        end
        check(n == NC*NC+1+em, "R8", "busy start latency", n, NC*NC+1+em);
        check(freq_lvl == 4'(el), "R8", "busy start level", int'(freq_lvl), el);
        check(peak_temp == 10'(ep), "R8", "busy start peak", int'(peak_temp), ep);

        // R9 hold and R8 no second result
        hl = freq_lvl; hp = peak_temp; extra = 0;
        repeat (40) begin
            @(negedge clk);
            if (done) extra++;
        end
        check(extra == 0, "R8", "second done count", extra, 0);
        check(freq_lvl == hl, "R9", "hold level", int'(freq_lvl), int'(hl));
        check(peak_temp == hp, "R9", "hold peak", int'(peak_temp), int'(hp));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule